// File: doc/BRIEF.md
# USB Endpoint Interrupt Summary Register

This block gathers the interrupt activity of five USB endpoints into one 8-bit status register on a small controller's special-function-register bus. Each endpoint delivers an 8-bit request vector. The block keeps one sticky summary flag per endpoint, which sets when that endpoint's requests go from all-quiet to any-active. It also keeps one device-request flag, which sets when the device-request decoder reports a configuration value, an alternate setting or an interface number from the host.

Software reads the summary at SFR address 0xD6 and learns which endpoints need attention. It then reads that endpoint's own request register. That read, reported to this block by a per-endpoint strobe, clears the summary flag. The device flag is cleared only by software, which writes a zero to bit 7. The flags are combined with per-endpoint, USB-endpoint and global enables to drive a registered endpoint interrupt line. A separately enabled, registered device interrupt line is driven as well.

Top module: `ep_irq_summary`

## Requirements
- R1: After synchronous reset the summary reads 0x00, and both `ep_irq` and `dev_irq` are low.
- R2: While `sfr_rd` is high and `sfr_addr` is 0xD6, `sfr_rdata` shows in the same cycle bit 7 = device flag, bits 6:5 = 0 and bit n = flag of endpoint n (n = 0..4). For any other address, or with `sfr_rd` low, `sfr_rdata` is 0x00.
- R3: Endpoint n's flag sets at a clock edge where the OR of `ep_req[8n+7:8n]` is high and was low at the previous edge (low is also assumed at reset). A request that stays active does not set the flag again after it has been cleared.
- R4: Endpoint n's flag clears at the edge that ends a cycle with `ep_reg_rd[n]` high. The flags of other endpoints are unaffected, and a flag otherwise holds.
- R5: If endpoint n's flag would be set (R3) in the same cycle that `ep_reg_rd[n]` is high, the flag is 1 after that edge.
- R6: The device flag (bit 7) sets at the edge ending any cycle in which `dreq_cfg`, `dreq_alt` or `dreq_intf` is high.
- R7: A write (`sfr_wr`) to 0xD6 with `sfr_wdata[7]` = 0 clears the device flag, and with bit 7 = 1 it has no effect. Writes never change bits 4:0 or make bits 6:5 nonzero. Writes to other addresses change nothing, and hardware never clears the device flag.
- R8: When a device-request strobe and a clearing write occur in the same cycle, the device flag is 1 afterwards.
- R9: `ep_irq` is high in the cycle after one in which `glb_ie`, `usb_ep_ie` and at least one endpoint with both its flag and its `ep_ie` bit set were all true, and low otherwise.
- R10: `dev_irq` is high in the cycle after one in which the device flag and `dev_ie` were both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational |
| ep_req | input | 40 | Request vectors, endpoint n on bits 8n+7:8n |
| ep_reg_rd | input | 5 | Per-endpoint strobe: the endpoint's own request register is being read |
| dreq_cfg | input | 1 | Decoder strobe: configuration value received |
| dreq_alt | input | 1 | Decoder strobe: alternate setting received |
| dreq_intf | input | 1 | Decoder strobe: interface number received |
| ep_ie | input | 5 | Per-endpoint interrupt enables |
| glb_ie | input | 1 | Global interrupt enable |
| usb_ep_ie | input | 1 | USB endpoint interrupt enable |
| dev_ie | input | 1 | Device-request interrupt enable |
| ep_irq | output | 1 | Registered endpoint interrupt line |
| dev_irq | output | 1 | Registered device interrupt line |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that a set and a clear of the same flag may arrive together, so the ordering between them is checked rather than excluded. The stimulus changes inputs only at the falling edge. It mixes random request vectors, read strobes, bus writes and enables with directed cases that force coincident set and clear, requests held across a clear, and writes of one and zero to bit 7.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int EP_COUNT = 5;
    localparam int REQ_BITS = 8;
    localparam int SFR_W    = 8;
    localparam int DEV_BIT  = SFR_W - 1;
    localparam int RSV_W    = SFR_W - 1 - EP_COUNT;
    localparam logic [SFR_W-1:0] SUM_ADDR = 8'hD6;
    localparam logic [SFR_W-1:0] DEV_MASK = SFR_W'(1) << DEV_BIT;

    typedef struct packed {
        logic                dev;
        logic [RSV_W-1:0]    rsv;
        logic [EP_COUNT-1:0] ep;
    } sum_reg_t;

    typedef struct packed {
        logic cfg;
        logic alt;
        logic intf;
    } dev_evt_t;

    typedef struct packed {
        logic                glb;
        logic                usb_ep;
        logic                dev;
        logic [EP_COUNT-1:0] ep;
    } irq_en_t;

    function automatic sum_reg_t pack_sum(logic dev, logic [EP_COUNT-1:0] ep);
        sum_reg_t s;
        s.dev = dev;
        s.rsv = '0;
        s.ep  = ep;
        return s;
    endfunction

    function automatic logic wr_clears_dev(logic [SFR_W-1:0] wd);
        return (wd & DEV_MASK) == '0;
    endfunction
endpackage

// File: rtl/ep_flag_cell.sv
module ep_flag_cell #(
    parameter int REQ_BITS = ep_irq_pkg::REQ_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REQ_BITS-1:0] req,
    input  logic                rd_clr,
    output logic                flag
);
    logic prev_q;
    logic req_any;
    logic rise;

    assign req_any = |req;
    assign rise    = req_any && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= req_any;
            if (rise)
                flag <= 1'b1;
            else if (rd_clr)
                flag <= 1'b0;
        end
    end

    assert_set_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (req_any && !prev_q) |=> flag);
    assert_no_reset_while_held_R3: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(req_any && !prev_q)) |=> !flag);
    assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !(req_any && !prev_q)) |=> !flag);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_clr) |=> flag);
    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && req_any && !prev_q) |=> flag);
endmodule

// File: rtl/dev_req_flag.sv
module dev_req_flag
    import ep_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dev_evt_t evt,
    input  logic     clr_wr,
    output logic     flag
);
    logic evt_any;

    assign evt_any = evt.cfg || evt.alt || evt.intf;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (evt_any)
            flag <= 1'b1;
        else if (clr_wr)
            flag <= 1'b0;
    end

    assert_dev_set_R6: assert property (@(posedge clk) disable iff (rst)
        evt_any |=> flag);
    assert_dev_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !evt_any) |=> !flag);
    assert_dev_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr) |=> flag);
    assert_dev_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && evt_any) |=> flag);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
    import ep_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [EP_COUNT-1:0] ep_flags,
    input  logic                dev_flag,
    input  irq_en_t             en,
    output logic                ep_irq,
    output logic                dev_irq
);
    logic ep_cond;
    logic dev_cond;

    assign ep_cond  = en.glb && en.usb_ep && (|(ep_flags & en.ep));
    assign dev_cond = dev_flag && en.dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_irq  <= 1'b0;
            dev_irq <= 1'b0;
        end else begin
            ep_irq  <= ep_cond;
            dev_irq <= dev_cond;
        end
    end

    assert_ep_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        ep_cond |=> ep_irq);
    assert_ep_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !ep_cond |=> !ep_irq);
    assert_dev_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
        dev_cond |=> dev_irq);
    assert_dev_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
        !dev_cond |=> !dev_irq);
endmodule

// File: rtl/ep_irq_summary.sv
module ep_irq_summary
    import ep_irq_pkg::*;
#(
    parameter logic [SFR_W-1:0] ADDR = SUM_ADDR
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SFR_W-1:0]             sfr_addr,
    input  logic                         sfr_rd,
    input  logic                         sfr_wr,
    input  logic [SFR_W-1:0]             sfr_wdata,
    output logic [SFR_W-1:0]             sfr_rdata,
    input  logic [EP_COUNT*REQ_BITS-1:0] ep_req,
    input  logic [EP_COUNT-1:0]          ep_reg_rd,
    input  logic                         dreq_cfg,
    input  logic                         dreq_alt,
    input  logic                         dreq_intf,
    input  logic [EP_COUNT-1:0]          ep_ie,
    input  logic                         glb_ie,
    input  logic                         usb_ep_ie,
    input  logic                         dev_ie,
    output logic                         ep_irq,
    output logic                         dev_irq
);
    logic [EP_COUNT-1:0] ep_flags;
    logic                dev_flag;
    logic                sel;
    logic                dev_clr;
    dev_evt_t            evt;
    irq_en_t             en;
    sum_reg_t            status;

    assign sel     = (sfr_addr == ADDR);
    assign dev_clr = sfr_wr && sel && wr_clears_dev(sfr_wdata);
    assign evt     = '{cfg: dreq_cfg, alt: dreq_alt, intf: dreq_intf};
    assign en      = '{glb: glb_ie, usb_ep: usb_ep_ie, dev: dev_ie, ep: ep_ie};

    for (genvar n = 0; n < EP_COUNT; n++) begin : g_ep
        ep_flag_cell #(.REQ_BITS(REQ_BITS)) cell_i (
            .clk    (clk),
            .rst    (rst),
            .req    (ep_req[n*REQ_BITS +: REQ_BITS]),
            .rd_clr (ep_reg_rd[n]),
            .flag   (ep_flags[n])
        );
    end

    dev_req_flag dev_i (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .clr_wr (dev_clr),
        .flag   (dev_flag)
    );

    irq_combine comb_i (
        .clk      (clk),
        .rst      (rst),
        .ep_flags (ep_flags),
        .dev_flag (dev_flag),
        .en       (en),
        .ep_irq   (ep_irq),
        .dev_irq  (dev_irq)
    );

    assign status    = pack_sum(dev_flag, ep_flags);
    assign sfr_rdata = (sfr_rd && sel) ? status : '0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (ep_flags == '0 && !dev_flag && !ep_irq && !dev_irq));
    assert_idle_bus_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !sfr_rd |-> (sfr_rdata == '0));
endmodule

// File: tb/ep_irq_summary_tb_top.sv
`timescale 1ns/1ps
module ep_irq_summary_tb_top;
    import ep_irq_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [SFR_W-1:0]             sfr_addr = '0;
    logic                         sfr_rd = 1'b0;
    logic                         sfr_wr = 1'b0;
    logic [SFR_W-1:0]             sfr_wdata = '0;
    logic [SFR_W-1:0]             sfr_rdata;
    logic [EP_COUNT*REQ_BITS-1:0] ep_req = '0;
    logic [EP_COUNT-1:0]          ep_reg_rd = '0;
    logic                         dreq_cfg = 1'b0, dreq_alt = 1'b0, dreq_intf = 1'b0;
    logic [EP_COUNT-1:0]          ep_ie = '0;
    logic                         glb_ie = 1'b0, usb_ep_ie = 1'b0, dev_ie = 1'b0;
    logic                         ep_irq, dev_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [EP_COUNT-1:0] m_ep = '0, m_prev = '0;
    logic                m_dev = 1'b0, m_epirq = 1'b0, m_devirq = 1'b0;

    always #2 clk = ~clk;

    ep_irq_summary dut_i (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ep_req(ep_req), .ep_reg_rd(ep_reg_rd),
        .dreq_cfg(dreq_cfg), .dreq_alt(dreq_alt), .dreq_intf(dreq_intf), .ep_ie(ep_ie),
        .glb_ie(glb_ie), .usb_ep_ie(usb_ep_ie), .dev_ie(dev_ie), .ep_irq(ep_irq), .dev_irq(dev_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [SFR_W-1:0] exp_rdata();
        if (sfr_rd && sfr_addr == 8'hD6) return {m_dev, 2'b00, m_ep};
        return 8'h00;
    endfunction

    // Called just after a falling edge with inputs already set for this cycle.
    task automatic tick(input string tag);
        logic [EP_COUNT-1:0] nxt_ep;
        logic                nxt_dev;
        logic                any;
        #1;
        check(tag, 32'(sfr_rdata), 32'(exp_rdata()));
        m_epirq  = glb_ie && usb_ep_ie && (|(m_ep & ep_ie));
        m_devirq = m_dev && dev_ie;
        nxt_ep = m_ep;
        for (int n = 0; n < EP_COUNT; n++) begin
            any = |ep_req[n*REQ_BITS +: REQ_BITS];
            if (any && !m_prev[n]) nxt_ep[n] = 1'b1;
            else if (ep_reg_rd[n]) nxt_ep[n] = 1'b0;
            m_prev[n] = any;
        end
        nxt_dev = m_dev;
        if (dreq_cfg || dreq_alt || dreq_intf) nxt_dev = 1'b1;
        else if (sfr_wr && sfr_addr == 8'hD6 && !sfr_wdata[7]) nxt_dev = 1'b0;
        m_ep  = nxt_ep;
        m_dev = nxt_dev;
        @(posedge clk);
        @(negedge clk);
        check("R9", 32'(ep_irq), 32'(m_epirq));
        check("R10", 32'(dev_irq), 32'(m_devirq));
    endtask

    task automatic idle();
        sfr_rd = 1'b0; sfr_wr = 1'b0; sfr_wdata = '0; sfr_addr = 8'h00;
        ep_reg_rd = '0; dreq_cfg = 1'b0; dreq_alt = 1'b0; dreq_intf = 1'b0;
    endtask

    task automatic peek(input string tag);
        idle();
        sfr_rd = 1'b1; sfr_addr = 8'hD6;
        tick(tag);
        idle();
    endtask

    task automatic set_ep(input int n, input logic [REQ_BITS-1:0] v);
        ep_req[n*REQ_BITS +: REQ_BITS] = v;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'd5407);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        peek("R1");
        check("R1", 32'(ep_irq), 32'd0);
        check("R1", 32'(dev_irq), 32'd0);

        // R3: set on rise, held request does not re-set
        set_ep(2, 8'h10); idle(); tick("R3");
        peek("R3");
        check("R3", 32'(m_ep[2]), 32'd1);
        idle(); ep_reg_rd[2] = 1'b1; tick("R4");
        peek("R3");                        // still held: flag must stay 0
        set_ep(2, 8'h00); idle(); tick("R3");
        set_ep(2, 8'h01); idle(); tick("R3");
        peek("R3");

        // R4: clear only the endpoint that was read
        set_ep(0, 8'h80); set_ep(4, 8'h02); idle(); tick("R4");
        idle(); ep_reg_rd[0] = 1'b1; tick("R4");
        peek("R4");

        // R5: rise and clear together
        set_ep(1, 8'h00); idle(); tick("R5");
        set_ep(1, 8'h40); idle(); ep_reg_rd[1] = 1'b1; tick("R5");
        peek("R5");

        // R6 and R7: each strobe, clear by writing 0 to bit 7
        idle(); dreq_cfg = 1'b1; tick("R6"); peek("R6");
        idle(); sfr_wr = 1'b1; sfr_addr = 8'hD6; sfr_wdata = 8'h80; tick("R7"); peek("R7");
        idle(); sfr_wr = 1'b1; sfr_addr = 8'hD5; sfr_wdata = 8'h00; tick("R7"); peek("R7");
        idle(); sfr_wr = 1'b1; sfr_addr = 8'hD6; sfr_wdata = 8'h7F; tick("R7"); peek("R7");
        idle(); dreq_alt = 1'b1; tick("R6"); peek("R6");
        idle(); sfr_wr = 1'b1; sfr_addr = 8'hD6; sfr_wdata = 8'h00; tick("R7");
        idle(); dreq_intf = 1'b1; tick("R6"); peek("R6");
        idle(); sfr_rd = 1'b1; sfr_addr = 8'hD7; tick("R2");

        // R8: strobe and clearing write together
        idle(); dreq_cfg = 1'b1; sfr_wr = 1'b1; sfr_addr = 8'hD6; sfr_wdata = 8'h00; tick("R8");
        peek("R8");

        // R9 and R10: enables gate the lines
        ep_ie = 5'b10000; glb_ie = 1'b1; usb_ep_ie = 1'b1; dev_ie = 1'b1;
        idle(); tick("R9"); idle(); tick("R9");
        glb_ie = 1'b0; idle(); tick("R9"); idle(); tick("R9");
        glb_ie = 1'b1; usb_ep_ie = 1'b0; idle(); tick("R9");
        dev_ie = 1'b0; idle(); tick("R10"); idle(); tick("R10");

        // random phase
        for (int c = 0; c < 4000; c++) begin
            idle();
            for (int n = 0; n < EP_COUNT; n++)
                if ($urandom % 4 == 0)
                    set_ep(n, ($urandom % 3 == 0) ? 8'h00 : 8'($urandom));
            sfr_rd   = 1'($urandom);
            sfr_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD6;
            sfr_wr   = ($urandom % 8 == 0);
            sfr_wdata = 8'($urandom);
            ep_reg_rd = 5'($urandom) & 5'($urandom);
            dreq_cfg  = ($urandom % 16 == 0);
            dreq_alt  = ($urandom % 16 == 0);
            dreq_intf = ($urandom % 16 == 0);
            if ($urandom % 16 == 0) begin
                ep_ie = 5'($urandom); glb_ie = 1'($urandom);
                usb_ep_ie = 1'($urandom); dev_ie = 1'($urandom);
            end
            tick("R2");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule